// File: doc/BRIEF.md
# Block-Floating-Point Radix-2 Butterfly

This block is the arithmetic core of an in-place radix-2 decimation-in-time FFT that keeps one shared exponent for the whole data array. On each valid input cycle it takes two complex operands A and B and a complex twiddle W. It rotates B by W, truncating the product back to the data's fractional width, and returns the sum X = A + W·B and the difference Y = A − W·B. The working memory, the address sequencing and the twiddle table stay outside. All arithmetic is fixed-point and no sample carries its own exponent.

In block-floating-point mode every sum and difference is tested against the signed range of the nominal data width. The flags are combined over a whole pass. When a pass ends with an overflow, every operand of the next pass is halved by a one-bit arithmetic right shift, and a block exponent counts the halvings. In full-growth mode nothing is scaled. The data ports are wide enough for the unscaled growth of the transform, which is the input width plus the stage count plus one. A start-of-frame strobe clears the exponent. A pass-end strobe, issued once the pipeline has drained, closes each pass.

Top module: `bfp_butterfly`

## Requirements
- R1: With W·B defined as re = floor((Bre·Wre − Bim·Wim) / 2^(TW−1)) and im = floor((Bre·Wim + Bim·Wre) / 2^(TW−1)), the outputs are X = A' + W·B and Y = A' − W·B. A' and B' are the operands after any pass halving. The twiddle is signed Q1.(TW−1), where 32767 is about +1 for TW = 16.
- R2: out_valid is high in the third cycle after the cycle in which in_valid is high. It is then high for exactly one cycle per butterfly, and the results are valid in that same cycle.
- R3: In block-floating-point mode (scale_bfp = 1), ovf is high together with out_valid when any of the four results lies outside the DW-bit signed range [−2^(DW−1), 2^(DW−1)−1]. Otherwise ovf is low.
- R4: If any result of a pass raised ovf, the pass_end pulse makes every A and B component of the following pass shift right by one bit arithmetically, so that −3 becomes −2 and 5 becomes 2. The twiddle is never shifted.
- R5: A pass without any overflow leaves the following pass unshifted, even if the pass before it was shifted.
- R6: The exponent output is one higher after the pass_end of each pass that overflowed, and it is unchanged after other passes. It saturates at STAGES. Halving of the next pass continues while it is saturated.
- R7: sof clears the exponent and any pending halving. It takes priority over a pass_end in the same cycle.
- R8: In full-growth mode (scale_bfp = 0), ovf stays low, no operand is halved, the exponent stays 0, and results are the full OW-bit values.
- R9: After reset, out_valid, ovf and the exponent are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scale_bfp | input | 1 | 1 = block-floating-point, 0 = full growth; changed only with sof |
| sof | input | 1 | Start-of-frame strobe |
| pass_end | input | 1 | End-of-pass strobe, given after the pipeline has drained |
| in_valid | input | 1 | Operands and twiddle valid |
| a_re | input | OW | Operand A real |
| a_im | input | OW | Operand A imaginary |
| b_re | input | OW | Operand B real |
| b_im | input | OW | Operand B imaginary |
| w_re | input | TW | Twiddle real |
| w_im | input | TW | Twiddle imaginary |
| out_valid | output | 1 | Results valid |
| x_re | output | OW | Sum real |
| x_im | output | OW | Sum imaginary |
| y_re | output | OW | Difference real |
| y_im | output | OW | Difference imaginary |
| ovf | output | 1 | Overflow of this butterfly (block mode) |
| exponent | output | EW | Block exponent, number of halvings |

## Verification
A wrong pending-halving flag shows up in the first butterfly of the next pass, three cycles after it enters: every result is off by about half, and odd negative operands round the wrong way. A stuck or miscounted exponent appears on the exponent port in the cycle after pass_end. A lost overflow flag shows both there and in the scaling of the pass that follows. Pipeline faults appear as a misplaced out_valid, or as wrong results in the first butterfly that is checked.

// File: rtl/bfp_pkg.sv
// Shared definitions for the block-floating-point butterfly.
// Assumes nothing beyond being compiled before the modules that import it.
package bfp_pkg;
    typedef enum logic {
        SCALE_FULL = 1'b0,
        SCALE_BFP  = 1'b1
    } scale_mode_e;
endpackage

// File: rtl/bfp_in_stage.sv
// Input register stage: captures operands and twiddle, halving the four
// operand components when the current pass is marked for scaling.
// Assumes lane order 0..3 = A re, A im, B re, B im.
module bfp_in_stage #(
    parameter int OW = 27,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 halve,
    input  logic signed [OW-1:0] din [4],
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 v_q,
    output logic signed [OW-1:0] d_q [4],
    output logic signed [TW-1:0] wr_q,
    output logic signed [TW-1:0] wi_q
);
    // Register operands (optionally halved) and twiddle on a valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= 1'b0;
            wr_q <= '0;
            wi_q <= '0;
            for (int i = 0; i < 4; i++) d_q[i] <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                wr_q <= w_re;
                wi_q <= w_im;
                for (int i = 0; i < 4; i++)
                    d_q[i] <= halve ? (din[i] >>> 1) : din[i];
            end
        end
    end
endmodule

// File: rtl/bfp_cmul.sv
// Complex twiddle multiply stage: four real products, two adds, then a
// floor truncation by TW-1 fractional bits. Delays A alongside.
// Assumes the twiddle is signed Q1.(TW-1) and the product fits OW bits.
module bfp_cmul #(
    parameter int OW = 27,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic signed [OW-1:0] d_in [4],
    input  logic signed [TW-1:0] wr,
    input  logic signed [TW-1:0] wi,
    output logic                 v_q,
    output logic signed [OW-1:0] a_q [2],
    output logic signed [OW-1:0] p_q [2]
);
    localparam int PW = OW + TW;

    logic signed [PW:0] br_x, bi_x, wr_x, wi_x;
    logic signed [PW:0] m_re, m_im;

    // Sign-extend operands to the product width and form both products.
    always_comb begin
        br_x = {{(TW+1){d_in[2][OW-1]}}, d_in[2]};
        bi_x = {{(TW+1){d_in[3][OW-1]}}, d_in[3]};
        wr_x = {{(OW+1){wr[TW-1]}}, wr};
        wi_x = {{(OW+1){wi[TW-1]}}, wi};
        m_re = br_x * wr_x - bi_x * wi_x;
        m_im = br_x * wi_x + bi_x * wr_x;
    end

    // Register truncated product and the delayed A operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                a_q[k] <= '0;
                p_q[k] <= '0;
            end
        end else begin
            v_q <= v_in;
            if (v_in) begin
                a_q[0] <= d_in[0];
                a_q[1] <= d_in[1];
                p_q[0] <= OW'(m_re >>> (TW-1));
                p_q[1] <= OW'(m_im >>> (TW-1));
            end
        end
    end
endmodule

// File: rtl/bfp_addsub.sv
// Sum/difference stage with per-result range test against DW-bit signed.
// Assumes in full-growth mode the results fit OW bits.
module bfp_addsub #(
    parameter int OW = 27,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic                 bfp_on,
    input  logic signed [OW-1:0] a_in [2],
    input  logic signed [OW-1:0] p_in [2],
    output logic                 out_valid,
    output logic signed [OW-1:0] x_q [2],
    output logic signed [OW-1:0] y_q [2],
    output logic                 ovf
);
    logic signed [OW:0] s_w [2];
    logic signed [OW:0] d_w [2];
    logic [3:0]         lane_bad;

    // True when the value is representable in DW signed bits.
    function automatic logic fits(input logic signed [OW:0] v);
        logic [OW-DW+1:0] hi;
        hi = v[OW:DW-1];
        return (&hi) | ~(|hi);
    endfunction

    for (genvar k = 0; k < 2; k++) begin : g_lane
        assign s_w[k] = {a_in[k][OW-1], a_in[k]} + {p_in[k][OW-1], p_in[k]};
        assign d_w[k] = {a_in[k][OW-1], a_in[k]} - {p_in[k][OW-1], p_in[k]};
        assign lane_bad[2*k]   = ~fits(s_w[k]);
        assign lane_bad[2*k+1] = ~fits(d_w[k]);
    end

    // Register results and the combined overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ovf       <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                x_q[k] <= '0;
                y_q[k] <= '0;
            end
        end else begin
            out_valid <= v_in;
            ovf       <= v_in & bfp_on & (|lane_bad);
            if (v_in) begin
                for (int k = 0; k < 2; k++) begin
                    x_q[k] <= OW'(s_w[k]);
                    y_q[k] <= OW'(d_w[k]);
                end
            end
        end
    end

    assert_ovf_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> out_valid);

    assert_sum_diff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (OW'(x_q[0] + y_q[0]) == OW'($past(a_in[0]) <<< 1)));
endmodule

// File: rtl/bfp_scale_ctrl.sv
// Pass scaling controller: ORs overflow flags over a pass, arms halving for
// the next pass and counts halvings in a saturating block exponent.
// Assumes pass_end comes only after all results of the pass have left.
module bfp_scale_ctrl
    import bfp_pkg::*;
#(
    parameter int STAGES = 10,
    parameter int EW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scale_bfp,
    input  logic          sof,
    input  logic          pass_end,
    input  logic          res_valid,
    input  logic          res_ovf,
    output logic          halve,
    output logic [EW-1:0] exponent
);
    localparam logic [EW-1:0] EXP_MAX = EW'(STAGES);

    scale_mode_e mode;
    logic        pass_ovf;
    logic        pass_any;

    assign mode     = scale_mode_e'(scale_bfp);
    assign pass_any = pass_ovf | (res_valid & res_ovf);

    // Track overflow over the pass; at pass end update halving and exponent.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) begin
            pass_ovf <= 1'b0;
            halve    <= 1'b0;
            exponent <= '0;
        end else if (pass_end) begin
            pass_ovf <= 1'b0;
            halve    <= (mode == SCALE_BFP) & pass_any;
            if ((mode == SCALE_BFP) && pass_any && exponent < EXP_MAX)
                exponent <= exponent + 1'b1;
        end else if (res_valid && res_ovf) begin
            pass_ovf <= 1'b1;
        end
    end

    assert_exp_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exponent <= EXP_MAX);

    assert_exp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exponent != $past(exponent)) |-> (exponent == $past(exponent) + 1'b1 || exponent == '0));

    assert_halve_at_pass_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halve) |-> $past(pass_end));
endmodule

// File: rtl/bfp_butterfly.sv
// Top: radix-2 DIT butterfly with block-floating-point pass scaling.
// Three register stages: input/halve, twiddle multiply, add/subtract.
// Assumes scale_bfp changes only together with sof.
module bfp_butterfly #(
    parameter int DW     = 16,
    parameter int TW     = 16,
    parameter int STAGES = 10,
    parameter int OW     = DW + STAGES + 1,
    parameter int EW     = $clog2(STAGES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scale_bfp,
    input  logic                 sof,
    input  logic                 pass_end,
    input  logic                 in_valid,
    input  logic signed [OW-1:0] a_re,
    input  logic signed [OW-1:0] a_im,
    input  logic signed [OW-1:0] b_re,
    input  logic signed [OW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 out_valid,
    output logic signed [OW-1:0] x_re,
    output logic signed [OW-1:0] x_im,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im,
    output logic                 ovf,
    output logic [EW-1:0]        exponent
);
    logic signed [OW-1:0] din [4];
    logic signed [OW-1:0] d1 [4];
    logic signed [TW-1:0] wr1, wi1;
    logic signed [OW-1:0] a2 [2];
    logic signed [OW-1:0] p2 [2];
    logic signed [OW-1:0] xo [2];
    logic signed [OW-1:0] yo [2];
    logic                 v1, v2, halve;

    assign din[0] = a_re;
    assign din[1] = a_im;
    assign din[2] = b_re;
    assign din[3] = b_im;

    bfp_in_stage #(.OW(OW), .TW(TW)) u_in (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .halve(halve & scale_bfp),
        .din(din), .w_re(w_re), .w_im(w_im),
        .v_q(v1), .d_q(d1), .wr_q(wr1), .wi_q(wi1)
    );

    bfp_cmul #(.OW(OW), .TW(TW)) u_mul (
        .clk(clk), .rst_n(rst_n), .v_in(v1), .d_in(d1), .wr(wr1), .wi(wi1),
        .v_q(v2), .a_q(a2), .p_q(p2)
    );

    bfp_addsub #(.OW(OW), .DW(DW)) u_as (
        .clk(clk), .rst_n(rst_n), .v_in(v2), .bfp_on(scale_bfp),
        .a_in(a2), .p_in(p2),
        .out_valid(out_valid), .x_q(xo), .y_q(yo), .ovf(ovf)
    );

    bfp_scale_ctrl #(.STAGES(STAGES), .EW(EW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .scale_bfp(scale_bfp), .sof(sof),
        .pass_end(pass_end), .res_valid(out_valid), .res_ovf(ovf),
        .halve(halve), .exponent(exponent)
    );

    assign x_re = xo[0];
    assign x_im = xo[1];
    assign y_re = yo[0];
    assign y_im = yo[1];

    assert_full_mode_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !scale_bfp |-> !ovf);
endmodule

// File: tb/sim_bfp_butterfly.sv
module sim_bfp_butterfly;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int TW = 16;
    localparam int STAGES = 10;
    localparam int OW = DW + STAGES + 1;
    localparam int EW = $clog2(STAGES + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scale_bfp = 1'b1, sof = 1'b0, pass_end = 1'b0, in_valid = 1'b0;
    logic signed [OW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [TW-1:0] w_re = '0, w_im = '0;
    logic out_valid, ovf;
    logic signed [OW-1:0] x_re, x_im, y_re, y_im;
    logic [EW-1:0] exponent;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfp_butterfly #(.DW(DW), .TW(TW), .STAGES(STAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .scale_bfp(scale_bfp), .sof(sof), .pass_end(pass_end),
        .in_valid(in_valid), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im), .out_valid(out_valid), .x_re(x_re), .x_im(x_im),
        .y_re(y_re), .y_im(y_im), .ovf(ovf), .exponent(exponent)
    );

    typedef struct {
        longint xr, xi, yr, yi;
        logic   ov;
        int     cyc;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0, errors = 0, cyc = 0;
    logic   m_shift = 1'b0, m_pass_ovf = 1'b0;
    int     m_exp = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic out_of_range(input longint v);
        return (v > 32767) || (v < -32768);
    endfunction

    // Driver: compute expected result (R1, R3, R4, R8), push, drive one cycle.
    task automatic bfly(input longint ar, ai, br, bi, wr, wi, input string tag);
        exp_t e;
        longint pr, pi, sa_r, sa_i, sb_r, sb_i;
        logic sh;
        sh   = m_shift & scale_bfp;
        sa_r = sh ? (ar >>> 1) : ar;
        sa_i = sh ? (ai >>> 1) : ai;
        sb_r = sh ? (br >>> 1) : br;
        sb_i = sh ? (bi >>> 1) : bi;
        pr = (sb_r * wr - sb_i * wi) >>> (TW-1);
        pi = (sb_r * wi + sb_i * wr) >>> (TW-1);
        e.xr = sa_r + pr; e.xi = sa_i + pi;
        e.yr = sa_r - pr; e.yi = sa_i - pi;
        e.ov = scale_bfp & (out_of_range(e.xr) | out_of_range(e.xi) |
                            out_of_range(e.yr) | out_of_range(e.yi));
        if (e.ov) m_pass_ovf = 1'b1;
        e.cyc = cyc + 3;
        e.tag = tag;
        sb.push_back(e);
        a_re = OW'(ar); a_im = OW'(ai); b_re = OW'(br); b_im = OW'(bi);
        w_re = TW'(wr); w_im = TW'(wi);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Close a pass after draining; check the exponent (R5, R6).
    task automatic end_pass(input string tag);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        pass_end = 1'b1;
        if (scale_bfp && m_pass_ovf) begin
            m_shift = 1'b1;
            if (m_exp < STAGES) m_exp++;
        end else begin
            m_shift = 1'b0;
        end
        m_pass_ovf = 1'b0;
        @(negedge clk);
        pass_end = 1'b0;
        check({tag, " exponent"}, longint'(exponent), longint'(m_exp));
    endtask

    task automatic start_frame(input logic with_pass_end);
        sof = 1'b1;
        pass_end = with_pass_end;
        m_shift = 1'b0; m_pass_ovf = 1'b0; m_exp = 0;
        @(negedge clk);
        sof = 1'b0;
        pass_end = 1'b0;
        check("R7 exponent after sof", longint'(exponent), 0);
    endtask

    // Monitor: pop expected item and compare when a result appears (R1, R2, R3).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R2 latency"}, cyc, e.cyc);
                check({e.tag, " x_re"}, longint'(x_re), e.xr);
                check({e.tag, " x_im"}, longint'(x_im), e.xi);
                check({e.tag, " y_re"}, longint'(y_re), e.yr);
                check({e.tag, " y_im"}, longint'(y_im), e.yi);
                check({e.tag, " R3 ovf"}, longint'(ovf), longint'(e.ov));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 out_valid reset", longint'(out_valid), 0);
        check("R9 ovf reset", longint'(ovf), 0);
        check("R9 exponent reset", longint'(exponent), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Block mode, pass without overflow (R1, R5).
        scale_bfp = 1'b1;
        start_frame(1'b0);
        bfly(1000, -2000, 300, -700, 23170, -23170, "R1 p1a");
        bfly(-5, 7, -3, 1, 32767, 0, "R1 p1b");
        bfly(12000, 4000, -9000, 8000, -16384, 28377, "R1 p1c");
        end_pass("R5 p1");

        // Overflowing pass (R3, R6).
        bfly(100, 100, 10, 10, 32767, 0, "R3 p2 ok");
        bfly(30000, -100, 30000, 50, 32767, 0, "R3 p2 ovf");
        end_pass("R6 p2");

        // Halved pass with odd negatives (R4), no overflow.
        bfly(-3, 5, -7, 9, 32767, -1, "R4 p3a");
        bfly(1001, -1001, 333, -333, 16384, 16384, "R4 p3b");
        end_pass("R5 p3");

        // Following pass is unshifted again (R5).
        bfly(-3, 5, -7, 9, 32767, 0, "R5 p4");
        end_pass("R5 p4");

        // Saturation of the exponent (R6).
        for (int p = 0; p < STAGES + 1; p++) begin
            bfly(100000, 0, 100000, 0, 32767, 0, "R6 sat");
            end_pass("R6 sat");
        end
        check("R6 saturated exponent", longint'(exponent), STAGES);

        // sof wins over pass_end with a pending overflow (R7).
        bfly(100000, 0, 100000, 0, 32767, 0, "R7 pre");
        repeat (4) @(negedge clk);
        start_frame(1'b1);
        bfly(-3, 5, -7, 9, 32767, 0, "R7 unshifted");
        end_pass("R7 after");

        // Full-growth mode (R8).
        scale_bfp = 1'b0;
        start_frame(1'b0);
        bfly(100000, -90000, 100000, 70000, 32767, -16384, "R8 big");
        bfly(-3, 5, -7, 9, 32767, 0, "R8 small");
        end_pass("R8 p1");
        bfly(-3, 5, -7, 9, 32767, 0, "R8 no halve");
        end_pass("R8 p2");

        repeat (5) @(negedge clk);
        check("R2 queue drained", longint'(sb.size()), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule